// File: doc/BRIEF.md
# Compare-Channel System Timer

A free-running counter advances by one on every cycle in which the tick enable is high. Several compare channels each hold a match value and watch the low half of that count. When the counter steps onto a channel's match value, the channel raises a sticky status flag. The hardware never moves the match value on its own. For a periodic event, software adds the interval to the match register after each hit, and it drops the flag by writing a one to that flag's bit position.

A per-channel interrupt enable gates each flag onto its own interrupt line, so channel n drives line n. When software clears a flag, the line goes low with it, and no separate acknowledge exists. The flags can be polled at any time, whether or not the interrupt is enabled. A read-only pending word shows the gated lines.

Software reaches the block over a word-addressed register port with single-cycle read and write strobes. Read data comes back one cycle after the read strobe, qualified by a valid pulse. This port is a control path with no back-pressure: every strobe is accepted in the cycle it is given.

Top module: `match_timer`

## Requirements
- R1: The counter resets to zero, increments by one on each clock edge where `tick_en` is high, holds when `tick_en` is low, and wraps from all ones to zero.
- R2: Flag n (bit n of the status word at address 0) sets on the clock edge where a tick moves the counter's low half onto the value of match register n (address 3+n). Several channels can be set at once.
- R3: A write to address 0 clears flag n for every data bit n that is one. Bits that are zero leave their flags unchanged.
- R4: If a match and a clear for the same channel fall on the same edge, the flag ends set.
- R5: Matching is one-shot and only takes place on a tick. A match value equal to the current or an already-passed low count does not set the flag until the low half wraps around and steps onto it. A match register changes only when software writes to it.
- R6: Interrupt line n is high exactly when flag n and enable bit n are both set. The enables are bits [3:0] of address 7.
- R7: Clearing flag n also drops interrupt line n on the same edge, with no other acknowledge.
- R8: A flag sets and reads back at address 0 even when its interrupt enable is clear.
- R9: The read map is: 0 for status, 1 for the counter low half, 2 for the counter high half, 3 to 6 for match 0 to 3, 7 for the enables, and 8 for pending (the interrupt lines). Other addresses read zero, and narrow fields are zero-extended. Read data and `bus_rvalid` appear one cycle after `bus_rd` and reflect the state in the strobe cycle. All registers reset to zero.
- R10: Writes to addresses 1, 2, 8 and unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | NUM_CH | Gated interrupt lines, one per channel |

## Verification
The bench builds the timer with `CNT_W=16` and four channels. The compared low half is then 8 bits wide, so it wraps every 256 ticks and the whole counter wraps after 65,536. This puts within a short run the one-shot rule for a passed match value, the re-arming by wrap-around, the carry into the high half and the full rollover to zero. The same-edge set-versus-clear race is also staged on an exact cycle.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int BUS_AW = 4;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] A_STATUS = 4'd0;
  localparam logic [BUS_AW-1:0] A_CNT_LO = 4'd1;
  localparam logic [BUS_AW-1:0] A_CNT_HI = 4'd2;
  localparam logic [BUS_AW-1:0] A_MATCH0 = 4'd3;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int CNT_W = 64,
  parameter int LO_W  = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [LO_W-1:0]  nxt_lo
);
  logic [CNT_W-1:0] cnt_inc;

  // Value the counter takes on a tick; channels compare against it so a
  // hit lands on the same edge the counter reaches the match value.
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign nxt_lo  = cnt_inc[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel #(
  parameter int LO_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic [LO_W-1:0] nxt_lo,
  input  logic            match_we,
  input  logic [LO_W-1:0] match_wdata,
  input  logic            clr,
  input  logic            irq_en,
  output logic [LO_W-1:0] match_q,
  output logic            flag_q,
  output logic            irq_o
);
  logic hit;

  // Equality is tested only on a tick, against the value being entered.
  assign hit = tick_en && (nxt_lo == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (match_we) match_q <= match_wdata;
      flag_q <= hit | (flag_q & ~clr);   // set has priority over clear
    end
  end

  assign irq_o = flag_q & irq_en;
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
  import mtmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 64,
  parameter int LO_W   = CNT_W / 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  bus_req_t                     req,
  input  logic [CNT_W-1:0]             cnt_q,
  input  logic [NUM_CH-1:0][LO_W-1:0]  match_q,
  input  logic [NUM_CH-1:0]            flag_q,
  input  logic [NUM_CH-1:0]            pend,
  output logic [NUM_CH-1:0]            match_we,
  output logic [LO_W-1:0]              match_wdata,
  output logic [NUM_CH-1:0]            clr,
  output logic [NUM_CH-1:0]            irq_en_q,
  output logic [BUS_DW-1:0]            rdata_q,
  output logic                         rvalid_q
);
  localparam int HI_W = CNT_W - LO_W;
  localparam logic [BUS_AW-1:0] EN_A   = BUS_AW'(int'(A_MATCH0) + NUM_CH);
  localparam logic [BUS_AW-1:0] PEND_A = BUS_AW'(int'(A_MATCH0) + NUM_CH + 1);

  logic              en_we;
  logic [BUS_DW-1:0] rd_mux;

  assign match_wdata = req.wdata[LO_W-1:0];
  assign en_we       = req.wr && (req.addr == EN_A);
  assign clr         = (req.wr && (req.addr == A_STATUS)) ? req.wdata[NUM_CH-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      match_we[i] = req.wr && (req.addr == BUS_AW'(int'(A_MATCH0) + i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     irq_en_q <= '0;
    else if (en_we) irq_en_q <= req.wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (req.addr == A_STATUS)      rd_mux[NUM_CH-1:0] = flag_q;
    else if (req.addr == A_CNT_LO) rd_mux[LO_W-1:0]   = cnt_q[LO_W-1:0];
    else if (req.addr == A_CNT_HI) rd_mux[HI_W-1:0]   = cnt_q[CNT_W-1:LO_W];
    else if (req.addr == EN_A)     rd_mux[NUM_CH-1:0] = irq_en_q;
    else if (req.addr == PEND_A)   rd_mux[NUM_CH-1:0] = pend;
    for (int i = 0; i < NUM_CH; i++)
      if (req.addr == BUS_AW'(int'(A_MATCH0) + i)) rd_mux[LO_W-1:0] = match_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req.rd;
      rdata_q  <= req.rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CH-1:0] irq
);
  localparam int LO_W = CNT_W / 2;

  bus_req_t                    req;
  logic [CNT_W-1:0]            cnt_q;
  logic [LO_W-1:0]             nxt_lo;
  logic [NUM_CH-1:0][LO_W-1:0] match_q;
  logic [NUM_CH-1:0]           flag_q;
  logic [NUM_CH-1:0]           irq_en_q;
  logic [NUM_CH-1:0]           match_we;
  logic [NUM_CH-1:0]           clr;
  logic [LO_W-1:0]             match_wdata;

  assign req.wr    = bus_wr;
  assign req.rd    = bus_rd;
  assign req.addr  = bus_addr;
  assign req.wdata = bus_wdata;

  mtmr_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_q(cnt_q), .nxt_lo(nxt_lo)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    mtmr_channel #(.LO_W(LO_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .nxt_lo(nxt_lo),
      .match_we(match_we[n]), .match_wdata(match_wdata), .clr(clr[n]),
      .irq_en(irq_en_q[n]), .match_q(match_q[n]), .flag_q(flag_q[n]),
      .irq_o(irq[n])
    );
  end

  mtmr_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .LO_W(LO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(req), .cnt_q(cnt_q), .match_q(match_q),
    .flag_q(flag_q), .pend(irq), .match_we(match_we), .match_wdata(match_wdata),
    .clr(clr), .irq_en_q(irq_en_q), .rdata_q(bus_rdata), .rvalid_q(bus_rvalid)
  );
endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker
  import mtmr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int NUM_CH = 4,
  parameter int LO_W   = CNT_W / 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_en,
  input logic                        bus_wr,
  input logic [3:0]                  bus_addr,
  input logic [NUM_CH-1:0]           clr_bits,
  input logic [NUM_CH-1:0]           irq,
  input logic [CNT_W-1:0]            cnt,
  input logic [NUM_CH-1:0][LO_W-1:0] match,
  input logic [NUM_CH-1:0]           flag,
  input logic [NUM_CH-1:0]           irq_en
);
  logic [LO_W-1:0]   step_lo;
  logic [NUM_CH-1:0] hit;
  logic              st_wr;

  assign step_lo = cnt[LO_W-1:0] + LO_W'(1);
  assign st_wr   = bus_wr && (bus_addr == A_STATUS);
  always_comb
    for (int i = 0; i < NUM_CH; i++) hit[i] = tick_en && (step_lo == match[i]);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == $past(cnt) + CNT_W'(1));
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_p
    localparam logic [3:0] MA = 4'(int'(A_MATCH0) + n);
    assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] |=> flag[n]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && clr_bits[n] && !hit[n]) |=> !flag[n]);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && clr_bits[n] && hit[n]) |=> flag[n]);
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[n] && !flag[n]) |=> !flag[n]);
    assert_match_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == MA) |=> $stable(match[n]));
    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en[n] |-> !irq[n]);
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[n] && flag[n]) |-> irq[n]);
  end
endmodule

bind match_timer mtmr_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .clr_bits(bus_wdata[NUM_CH-1:0]), .irq(irq),
  .cnt(cnt_q), .match(match_q), .flag(flag_q), .irq_en(irq_en_q)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  match_timer #(.CNT_W(16), .NUM_CH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  // Reference model built from the requirements
  logic [15:0] mcnt;
  logic [3:0]  mflag, men;
  logic [7:0]  mmatch [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0; mflag <= '0; men <= '0;
      for (int c = 0; c < 4; c++) mmatch[c] <= '0;
    end else begin
      if (tick_en) mcnt <= mcnt + 16'd1;
      for (int c = 0; c < 4; c++) begin
        mflag[c] <= (tick_en && (8'(mcnt[7:0] + 8'd1) == mmatch[c])) ||
                    (mflag[c] && !(bus_wr && bus_addr == 4'd0 && bus_wdata[c]));
        if (bus_wr && bus_addr == 4'(3 + c)) mmatch[c] <= bus_wdata[7:0];
      end
      if (bus_wr && bus_addr == 4'd7) men <= bus_wdata[3:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] v = '0;
    case (a)
      4'd0: v[3:0] = mflag;
      4'd1: v[7:0] = mcnt[7:0];
      4'd2: v[7:0] = mcnt[15:8];
      4'd3, 4'd4, 4'd5, 4'd6: v[7:0] = mmatch[int'(a) - 3];
      4'd7: v[3:0] = men;
      4'd8: v[3:0] = mflag & men;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk({28'd0, irq}, {28'd0, mflag & men}, "R6 R7 irq lines");
      if (bus_rvalid) begin
        if (exp_q.size() == 0) chk(32'd1, 32'd0, "R9 unexpected rvalid");
        else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [3:0] a, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp_read(a)); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    // Reset state, R9
    rd(4'd0, "R9 reset status"); rd(4'd1, "R9 reset cnt lo");
    rd(4'd2, "R9 reset cnt hi"); rd(4'd3, "R9 reset match0");
    rd(4'd7, "R9 reset enables"); rd(4'd8, "R9 reset pending");
    chk(bus_rdata, 32'd0, "R9 reset rdata");
    // R1 hold and count
    idle(3); rd(4'd1, "R1 hold while tick low");
    tick_en = 1'b1; idle(7);
    rd(4'd1, "R1 count"); rd(4'd9, "R9 unmapped reads zero");
    // R10 ignored writes
    wr(4'd1, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd8, 32'hF); wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd1, "R10 cnt lo after write"); rd(4'd2, "R10 cnt hi after write");
    rd(4'd0, "R10 status after write"); rd(4'd8, "R10 pending after write");
    rd(4'd12, "R10 unmapped after write");
    // R2 single and multiple channels, flags stay polled with enables off (R8)
    wr(4'd3, {24'd0, 8'(mcnt[7:0] + 8'd30)});
    idle(40); rd(4'd0, "R2 R8 status ch0");
    chk({31'd0, mflag[0]}, 32'd1, "R2 model sanity ch0");
    wr(4'd4, {24'd0, 8'(mcnt[7:0] + 8'd10)});
    wr(4'd6, {24'd0, 8'(mcnt[7:0] + 8'd10)});
    idle(20); rd(4'd0, "R2 status multi"); rd(4'd4, "R9 match1 read");
    // R3 write-one-to-clear
    wr(4'd0, 32'h2); rd(4'd0, "R3 clear ch1 only");
    wr(4'd0, 32'h0); rd(4'd0, "R3 zero write no effect");
    wr(4'd0, 32'hF); rd(4'd0, "R3 clear all");
    // R5 passed value is one-shot, re-armed only by wrap
    wr(4'd5, {24'd0, mcnt[7:0]});
    idle(100); rd(4'd0, "R5 no set for passed value"); rd(4'd5, "R5 match unchanged");
    idle(200); rd(4'd0, "R5 set after wrap"); rd(4'd5, "R5 match not advanced");
    // R6 R7 R8 gating
    wr(4'd0, 32'hF);
    wr(4'd7, 32'h5);
    wr(4'd3, {24'd0, 8'(mcnt[7:0] + 8'd8)});
    wr(4'd4, {24'd0, 8'(mcnt[7:0] + 8'd8)});
    idle(12);
    rd(4'd8, "R6 pending"); rd(4'd0, "R8 masked flag visible"); rd(4'd7, "R6 enables");
    wr(4'd0, 32'h1);
    chk({31'd0, irq[0]}, 32'd0, "R7 line drops with clear");
    rd(4'd8, "R7 pending after clear");
    // R4 same-edge set and clear
    wr(4'd0, 32'hF);
    wr(4'd6, {24'd0, 8'(mcnt[7:0] + 8'd6)});
    while (8'(mcnt[7:0] + 8'd1) != mmatch[3]) @(negedge clk);
    wr(4'd0, 32'h8);
    rd(4'd0, "R4 set wins");
    chk({31'd0, mflag[3]}, 32'd1, "R4 model sanity");
    // R1 carry and full wrap
    rd(4'd2, "R1 hi carry");
    while (mcnt != 16'hFFFE) @(negedge clk);
    rd(4'd2, "R1 hi before wrap");
    idle(2);
    rd(4'd2, "R1 hi after wrap"); rd(4'd1, "R1 lo after wrap");
    idle(3);
    chk(32'(exp_q.size()), 32'd0, "R9 every read answered");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule